// File: doc/BRIEF.md
# GPIO Configuration Register Bank

This block holds the live configuration for a bank of twelve general-purpose I/O pins and turns it into registered pad controls. After every reset it copies a default configuration image into its live registers. The image comes from nonvolatile storage outside the block and arrives here as a plain input bus. A host can then change the live settings through a simple write port and read them back through a registered read port. Writing the live registers never alters the image, so the next reset restores the defaults.

Each pin has its own output state, direction and read-inversion bit. The choice between push-pull and open-drain is made once per group of four pins. One global bit selects high-current drive, and it reaches only those pins that are set as outputs. Pad input levels pass through a two-flop synchroniser. They are then XORed with the inversion bits and returned through the read port.

Default image layout, with N = 12 pins and G = 3 groups: bits [N-1:0] hold the output state, [2N-1:N] the direction, [3N-1:2N] the inversion, [3N+G-1:3N] the open-drain group bits, and [3N+G] the high-current bit.

Top module: `gpio_cfg_bank`

## Requirements
- R1: While `rst` is high, every pad control output and `rd_data` are 0. For the LOAD_CYCLES (default 4) clock edges after `rst` falls, the live registers are loaded from `dflt_image`.
- R2: A write presented while the default load is still running is ignored. Once loading ends, readback returns the image values.
- R3: Register select codes are 0 = output state, 1 = direction (1 = output), 2 = inversion, 3 = open-drain group bits in `wr_data[2:0]`, 4 = high-current in `wr_data[0]`, 5 = pin readback (read-only). A write to codes 0 to 4 takes effect at the next clock edge. Writes to codes 5 to 7 have no effect.
- R4: A pin whose direction bit is 0 never has `pad_oe` asserted, whatever its state bit holds.
- R5: An open-drain output pin with state 1 has `pad_oe` low. With state 0 it has `pad_oe` high and `pad_out` low.
- R6: A push-pull output pin has `pad_oe` high and `pad_out` equal to its state bit.
- R7: `pad_od[i]` equals the open-drain bit of group i/4.
- R8: `pad_hi[i]` is the high-current bit ANDed with the pin's direction bit.
- R9: Readback code 5 returns `pad_in` XOR the inversion bits. The pad value passes through two synchroniser flops plus the read register, so `rd_data` shows it three edges after `pad_in` is sampled.
- R10: Live writes leave the defaults untouched. After a new reset, readback again shows the image values.
- R11: Pad controls are registered: they reflect a live register change one edge after that register updates. `rd_data` reflects `rd_addr` and the register contents one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dflt_image | input | 40 | Default configuration image |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | 12 | Write data |
| rd_addr | input | 3 | Register select for reads |
| rd_data | output | 12 | Registered read data |
| pad_in | input | 12 | Pad input levels (asynchronous) |
| pad_out | output | 12 | Pad output values |
| pad_oe | output | 12 | Pad output enables |
| pad_od | output | 12 | Per-pin open-drain select |
| pad_hi | output | 12 | Per-pin high-current select |

## Verification
The assertions assume that `rst` is held high for at least one edge at start-up. They also assume that `wr_en` is a clean synchronous strobe, so a live register can only change through a write after loading or through the load itself. The bench starts in reset and changes every input just after the falling edge, which keeps all stimulus synchronous except `pad_in`. The bench treats `pad_in` as asynchronous, yet still changes it only at those same points, so the synchroniser latency is deterministic. Writes are deliberately issued during the load window, to unused codes and after a second reset, so that the ignore and restore rules are exercised.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATE = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_INV   = 3'd2,
    SEL_OD    = 3'd3,
    SEL_HI    = 3'd4,
    SEL_PINS  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_cfg_pkg::*;
#(
  parameter int N_PINS      = 12,
  parameter int N_GRPS      = 3,
  parameter int LOAD_CYCLES = 4,
  localparam int IMG_W = 3*N_PINS + N_GRPS + 1,
  localparam int CNT_W = $clog2(LOAD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IMG_W-1:0]  dflt_image,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [N_PINS-1:0] wr_data,
  output logic [N_PINS-1:0] live_state,
  output logic [N_PINS-1:0] live_dir,
  output logic [N_PINS-1:0] live_inv,
  output logic [N_GRPS-1:0] live_od,
  output logic              live_hi,
  output logic              load_busy
);
  logic [CNT_W-1:0] load_cnt;

  assign load_busy = (load_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_cnt   <= CNT_W'(LOAD_CYCLES);
      live_state <= '0;
      live_dir   <= '0;
      live_inv   <= '0;
      live_od    <= '0;
      live_hi    <= 1'b0;
    end else if (load_busy) begin
      load_cnt   <= load_cnt - 1'b1;
      live_state <= dflt_image[N_PINS-1:0];
      live_dir   <= dflt_image[2*N_PINS-1:N_PINS];
      live_inv   <= dflt_image[3*N_PINS-1:2*N_PINS];
      live_od    <= dflt_image[3*N_PINS+N_GRPS-1:3*N_PINS];
      live_hi    <= dflt_image[3*N_PINS+N_GRPS];
    end else if (wr_en) begin
      case (wr_addr)
        SEL_STATE: live_state <= wr_data;
        SEL_DIR:   live_dir   <= wr_data;
        SEL_INV:   live_inv   <= wr_data;
        SEL_OD:    live_od    <= wr_data[N_GRPS-1:0];
        SEL_HI:    live_hi    <= wr_data[0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int N_PINS   = 12,
  parameter int GRP_SIZE = 4,
  localparam int N_GRPS = N_PINS / GRP_SIZE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] live_state,
  input  logic [N_PINS-1:0] live_dir,
  input  logic [N_GRPS-1:0] live_od,
  input  logic              live_hi,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_od,
  output logic [N_PINS-1:0] pad_hi
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam int GRP = p / GRP_SIZE;
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[p] <= 1'b0;
        pad_oe[p]  <= 1'b0;
        pad_od[p]  <= 1'b0;
        pad_hi[p]  <= 1'b0;
      end else begin
        pad_out[p] <= live_state[p];
        pad_oe[p]  <= live_dir[p] & (~live_od[GRP] | ~live_state[p]);
        pad_od[p]  <= live_od[GRP];
        pad_hi[p]  <= live_hi & live_dir[p];
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pins_sync
);
  logic [N_PINS-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1    <= '0;
      pins_sync <= '0;
    end else begin
      stage1    <= pad_in;
      pins_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int N_PINS      = 12,
  parameter int GRP_SIZE    = 4,
  parameter int LOAD_CYCLES = 4
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [3*N_PINS+N_PINS/GRP_SIZE:0]          dflt_image,
  input  logic                                       wr_en,
  input  logic [2:0]                                 wr_addr,
  input  logic [N_PINS-1:0]                          wr_data,
  input  logic [2:0]                                 rd_addr,
  output logic [N_PINS-1:0]                          rd_data,
  input  logic [N_PINS-1:0]                          pad_in,
  output logic [N_PINS-1:0]                          pad_out,
  output logic [N_PINS-1:0]                          pad_oe,
  output logic [N_PINS-1:0]                          pad_od,
  output logic [N_PINS-1:0]                          pad_hi
);
  localparam int N_GRPS = N_PINS / GRP_SIZE;

  logic [N_PINS-1:0] live_state, live_dir, live_inv, pins_sync, rd_next;
  logic [N_GRPS-1:0] live_od;
  logic              live_hi, load_busy;

  gpio_cfg_regs #(.N_PINS(N_PINS), .N_GRPS(N_GRPS), .LOAD_CYCLES(LOAD_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .dflt_image(dflt_image),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live_state(live_state), .live_dir(live_dir), .live_inv(live_inv),
    .live_od(live_od), .live_hi(live_hi), .load_busy(load_busy)
  );

  gpio_pin_drive #(.N_PINS(N_PINS), .GRP_SIZE(GRP_SIZE)) u_drive (
    .clk(clk), .rst(rst),
    .live_state(live_state), .live_dir(live_dir), .live_od(live_od), .live_hi(live_hi),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_hi(pad_hi)
  );

  gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pins_sync(pins_sync)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      SEL_STATE: rd_next = live_state;
      SEL_DIR:   rd_next = live_dir;
      SEL_INV:   rd_next = live_inv;
      SEL_OD:    rd_next[N_GRPS-1:0] = live_od;
      SEL_HI:    rd_next[0] = live_hi;
      SEL_PINS:  rd_next = pins_sync ^ live_inv;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk #(
  parameter int N_PINS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              load_busy,
  input logic [N_PINS-1:0] live_state,
  input logic [N_PINS-1:0] live_dir,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pad_od,
  input logic [N_PINS-1:0] pad_hi
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_hi == '0));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !load_busy) |=> ($stable(live_state) && $stable(live_dir)));

  p_input_no_oe_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pad_oe & ~$past(live_dir)) == '0));

  p_od_never_high_r5: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_out & pad_od) == '0);

  p_hi_needs_out_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pad_hi & ~$past(live_dir)) == '0));
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .load_busy(load_busy),
  .live_state(live_state), .live_dir(live_dir),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_hi(pad_hi)
);

// File: tb/gpio_cfg_bank_tb.sv
`timescale 1ns/1ps
module gpio_cfg_bank_tb;
  localparam int NP = 12;
  localparam int NG = 3;
  localparam int LC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3*NP+NG:0] dflt_image;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [NP-1:0] wr_data = '0, pad_in = '0;
  logic [NP-1:0] rd_data, pad_out, pad_oe, pad_od, pad_hi;

  int checks = 0, errors = 0, cycles = 0;
  bit started = 1'b0;

  always #2 clk = ~clk;

  gpio_cfg_bank #(.N_PINS(NP), .GRP_SIZE(4), .LOAD_CYCLES(LC)) u_dut (
    .clk(clk), .rst(rst), .dflt_image(dflt_image),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_hi(pad_hi)
  );

  // behavioural reference model
  int m_cnt;
  bit [NP-1:0] m_state, m_dir, m_inv, m_s1, m_s2, m_rd, m_po, m_oe, m_odo, m_hio;
  bit [NG-1:0] m_od;
  bit m_hi;

  always @(posedge clk) begin
    bit [NP-1:0] oe, odo, hio, rd;
    started <= 1'b1;
    cycles  <= cycles + 1;
    for (int i = 0; i < NP; i++) begin
      odo[i] = m_od[i/4];
      hio[i] = m_hi && m_dir[i];
      if (!m_dir[i]) oe[i] = 1'b0;
      else if (m_od[i/4]) oe[i] = !m_state[i];
      else oe[i] = 1'b1;
    end
    case (rd_addr)
      3'd0: rd = m_state;
      3'd1: rd = m_dir;
      3'd2: rd = m_inv;
      3'd3: rd = NP'(m_od);
      3'd4: rd = NP'(m_hi);
      3'd5: rd = m_s2 ^ m_inv;
      default: rd = '0;
    endcase
    if (rst) begin
      m_cnt <= LC; m_state <= '0; m_dir <= '0; m_inv <= '0; m_od <= '0; m_hi <= 1'b0;
      m_s1 <= '0; m_s2 <= '0; m_rd <= '0; m_po <= '0; m_oe <= '0; m_odo <= '0; m_hio <= '0;
    end else begin
      m_s1 <= pad_in; m_s2 <= m_s1; m_rd <= rd;
      m_po <= m_state; m_oe <= oe; m_odo <= odo; m_hio <= hio;
      if (m_cnt > 0) begin
        m_cnt   <= m_cnt - 1;
        m_state <= dflt_image[NP-1:0];
        m_dir   <= dflt_image[2*NP-1:NP];
        m_inv   <= dflt_image[3*NP-1:2*NP];
        m_od    <= dflt_image[3*NP+NG-1:3*NP];
        m_hi    <= dflt_image[3*NP+NG];
      end else if (wr_en) begin
        case (wr_addr)
          3'd0: m_state <= wr_data;
          3'd1: m_dir   <= wr_data;
          3'd2: m_inv   <= wr_data;
          3'd3: m_od    <= wr_data[NG-1:0];
          3'd4: m_hi    <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(input string tag, input bit [NP-1:0] act, input bit [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("R1 R2 R3 R9 R10 R11 rd_data", rd_data, m_rd);
      cmp("R5 R6 R11 pad_out", pad_out, m_po);
      cmp("R1 R4 R5 R6 pad_oe", pad_oe, m_oe);
      cmp("R7 pad_od", pad_od, m_odo);
      cmp("R8 pad_hi", pad_hi, m_hio);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input bit [2:0] a, input bit [NP-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      tick(1);
    end
  endtask

  initial begin
    dflt_image = {1'b1, 3'b010, 12'h00F, 12'h0FF, 12'hA5C};
    tick(3);                          // R1 reset state
    rst = 1'b0;
    wr(3'd1, 12'h000);                // R2 write during load ignored
    tick(LC);
    sweep_reads();                    // R2 defaults visible
    wr(3'd1, 12'hFFF);                // R3 all outputs
    wr(3'd0, 12'h3C5);                // R5 R6 state pattern
    wr(3'd3, 12'h005);                // R7 groups 0 and 2 open-drain
    tick(2);
    wr(3'd4, 12'h000);                // R8 low current
    wr(3'd1, 12'h0F0);                // R4 inputs on some pins
    wr(3'd4, 12'h001);
    wr(3'd5, 12'hFFF);                // R3 read-only code ignored
    wr(3'd7, 12'hFFF);
    sweep_reads();
    rd_addr = 3'd5;                   // R9 readback latency and inversion
    wr(3'd2, 12'hA0F);
    for (int k = 0; k < 40; k++) begin
      pad_in = NP'($urandom);
      if (k % 7 == 0) wr(3'd2, NP'($urandom));
      else tick(1);
    end
    for (int k = 0; k < 60; k++) begin  // R11 random writes
      if (k % 3 == 0) wr(3'($urandom_range(0, 7)), NP'($urandom));
      else begin rd_addr = 3'($urandom_range(0, 7)); tick(1); end
    end
    rst = 1'b1;                       // R10 defaults restored
    tick(2);
    rst = 1'b0;
    tick(LC + 1);
    sweep_reads();
    tick(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule